// File: doc/BRIEF.md
# Dual-Port Byte-Write RAM with Collision Flags

A synchronous RAM with two equal ports, A and B, on one shared clock. Each port has its own address, write data, per-byte write mask and a registered read output, and both ports reach the same word array. A write changes only the bytes whose mask bit is set. On a write, the port's own output shows the word as it stands after the write in the same access.

Same-address accesses by the two ports in one cycle are caught. When both ports write the same word, the word is overwritten with a fixed poison pattern and a sticky per-word corrupt bit is set. That bit is reported alongside every later read of the word. When one port writes a word that the other port reads, the memory takes the write normally and only the reader's result is flagged. Each port also has a valid output. It drops for any collision and for a partial-mask write, whose echoed word is not trusted.

Top module: `dp_bytewrite_ram`

## Requirements
- R1: After reset every word reads as zero with its corrupt flag clear, and the valid and collision outputs of both ports are low.
- R2: Mask bit i of a port writes only bits 8i+7 down to 8i of the addressed word. Bytes whose mask bit is 0 keep their previous contents.
- R3: Results appear one clock after the request. A port whose enable is low drives valid and collision low in the next cycle and holds its read data.
- R4: An enabled port with an all-ones mask and no collision shows the written word on its read data in the next cycle, with valid high.
- R5: A partial-mask write (mask neither all zeros nor all ones) returns the merged word with valid low.
- R6: If both ports write the same address in one cycle, both collision outputs go high and both valids go low. The word becomes the poison pattern, which is POISON_BYTE in every byte, and this pattern is also what both ports return.
- R7: If one port writes an address that the enabled other port reads (mask all zeros) in the same cycle, the writer's data is stored. The reader returns the word as it was before the write, with collision high and valid low. The writer's collision output stays low.
- R8: The corrupt flag of a poisoned word is returned high on each read of it, partial writes do not clear it, and a full-mask write without a collision clears it.
- R9: Writes from the two ports to different addresses in the same cycle both take effect.
- R10: An enabled port with an all-zeros mask is a plain read: it returns the stored word with valid high when no collision occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | NBYTES | Port A byte write mask |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | 8*NBYTES | Port A write data |
| a_dout | output | 8*NBYTES | Port A read data |
| a_vld | output | 1 | Port A read data trusted |
| a_coll | output | 1 | Port B wrote A's address in the same access |
| a_bad | output | 1 | Corrupt flag of the word returned on A |
| b_en | input | 1 | Port B access enable |
| b_we | input | NBYTES | Port B byte write mask |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | 8*NBYTES | Port B write data |
| b_dout | output | 8*NBYTES | Port B read data |
| b_vld | output | 1 | Port B read data trusted |
| b_coll | output | 1 | Port A wrote B's address in the same access |
| b_bad | output | 1 | Corrupt flag of the word returned on B |

## Verification
The embedded assertions check on every cycle the relations between one cycle's request and the next cycle's outputs. These are the collision flags and poison echo for write-write conflicts, the flagging of the reader in write-read conflicts, the invalid mark on partial writes, the write-first echo of full writes and the quiet outputs of an idle port. Effects that span many cycles can only be shown by the bench scenarios. These include byte contents surviving later masked writes, zeroed words after reset, a corrupt flag that outlives partial writes and clears on a full write, and simultaneous writes to different words. The bench scenarios compare such sequences against a reference array.

// File: rtl/dp_bytewrite_ram.sv
module dp_bytewrite_ram #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 3,
  parameter logic [7:0] POISON_BYTE = 8'hA5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_en,
  input  logic [NBYTES-1:0]     a_we,
  input  logic [ADDR_W-1:0]     a_addr,
  input  logic [8*NBYTES-1:0]   a_din,
  output logic [8*NBYTES-1:0]   a_dout,
  output logic                  a_vld,
  output logic                  a_coll,
  output logic                  a_bad,
  input  logic                  b_en,
  input  logic [NBYTES-1:0]     b_we,
  input  logic [ADDR_W-1:0]     b_addr,
  input  logic [8*NBYTES-1:0]   b_din,
  output logic [8*NBYTES-1:0]   b_dout,
  output logic                  b_vld,
  output logic                  b_coll,
  output logic                  b_bad
);
  localparam int BW = 8;
  localparam int DW = BW * NBYTES;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DW-1:0] POISON = {NBYTES{POISON_BYTE}};

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] bad_q;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] din,
                                          input logic [NBYTES-1:0] we);
    logic [DW-1:0] r;
    r = old;
    for (int i = 0; i < NBYTES; i++)
      if (we[i]) r[i*BW +: BW] = din[i*BW +: BW];
    return r;
  endfunction

  wire a_wr   = a_en & (|a_we);
  wire b_wr   = b_en & (|b_we);
  wire a_full = &a_we;
  wire b_full = &b_we;
  wire same   = (a_addr == b_addr);
  wire ww     = a_wr & b_wr & same;
  wire a_hit  = a_en & b_wr & same;
  wire b_hit  = b_en & a_wr & same;

  wire [DW-1:0] a_new = ww ? POISON : merge(mem[a_addr], a_din, a_we);
  wire [DW-1:0] b_new = ww ? POISON : merge(mem[b_addr], b_din, b_we);

  wire a_bad_n = ww | (~(a_wr & a_full) & bad_q[a_addr]);
  wire b_bad_n = ww | (~(b_wr & b_full) & bad_q[b_addr]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      bad_q <= '0;
    end else if (ww) begin
      mem[a_addr]   <= POISON;
      bad_q[a_addr] <= 1'b1;
    end else begin
      if (a_wr) begin
        mem[a_addr] <= a_new;
        if (a_full) bad_q[a_addr] <= 1'b0;
      end
      if (b_wr) begin
        mem[b_addr] <= b_new;
        if (b_full) bad_q[b_addr] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_dout <= '0; a_vld <= 1'b0; a_coll <= 1'b0; a_bad <= 1'b0;
      b_dout <= '0; b_vld <= 1'b0; b_coll <= 1'b0; b_bad <= 1'b0;
    end else begin
      a_vld  <= a_en & ~a_hit & ~(a_wr & ~a_full);
      a_coll <= a_hit;
      b_vld  <= b_en & ~b_hit & ~(b_wr & ~b_full);
      b_coll <= b_hit;
      if (a_en) begin
        a_dout <= a_new;
        a_bad  <= a_bad_n;
      end
      if (b_en) begin
        b_dout <= b_new;
        b_bad  <= b_bad_n;
      end
    end
  end

  p_ww_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && b_en && (|a_we) && (|b_we) && a_addr == b_addr)
      |=> (a_coll && b_coll && !a_vld && !b_vld && a_dout == POISON && b_dout == POISON && a_bad && b_bad));

  p_wr_reader_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we == '0 && b_en && (|b_we) && a_addr == b_addr)
      |=> (a_coll && !a_vld && !b_coll));

  p_wr_reader_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_we == '0 && a_en && (|a_we) && a_addr == b_addr)
      |=> (b_coll && !b_vld && !a_coll));

  p_partial_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && (|a_we) && !(&a_we)) |=> !a_vld);

  p_partial_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && (|b_we) && !(&b_we)) |=> !b_vld);

  p_full_echo_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && (&a_we) && !(b_en && (|b_we) && a_addr == b_addr))
      |=> (a_vld && a_dout == $past(a_din) && !a_bad));

  p_full_echo_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && (&b_we) && !(a_en && (|a_we) && a_addr == b_addr))
      |=> (b_vld && b_dout == $past(b_din) && !b_bad));

  p_idle_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !a_en) |=> (!a_vld && !a_coll && $stable(a_dout)));

  p_idle_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !b_en) |=> (!b_vld && !b_coll && $stable(b_dout)));
endmodule

// File: tb/test_dp_bytewrite_ram.sv
module test_dp_bytewrite_ram;
  localparam int AW = 8;
  localparam int NB = 3;
  localparam int DW = 8 * NB;
  localparam logic [DW-1:0] POISON = 24'hA5A5A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 0, b_en = 0;
  logic [NB-1:0] a_we = '0, b_we = '0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_din = '0, b_din = '0;
  logic [DW-1:0] a_dout, b_dout;
  logic a_vld, a_coll, a_bad, b_vld, b_coll, b_bad;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] rm [1 << AW];
  logic          rb [1 << AW];
  logic [DW-1:0] ea_dout = '0, eb_dout = '0;
  logic          ea_bad = 0, eb_bad = 0;

  always #4 clk = ~clk;

  dp_bytewrite_ram #(.ADDR_W(AW), .NBYTES(NB), .POISON_BYTE(8'hA5)) i_dp_bytewrite_ram (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din),
    .a_dout(a_dout), .a_vld(a_vld), .a_coll(a_coll), .a_bad(a_bad),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din),
    .b_dout(b_dout), .b_vld(b_vld), .b_coll(b_coll), .b_bad(b_bad));

  function automatic logic [DW-1:0] expand(input logic [NB-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction

  function automatic logic [DW-1:0] apply(input logic [DW-1:0] o, input logic [DW-1:0] d,
                                          input logic [NB-1:0] m);
    return (o & ~expand(m)) | (d & expand(m));
  endfunction

  function automatic string tag_of(input logic en, input logic [NB-1:0] we,
                                   input logic hit, input logic ww);
    if (ww) return "R6";
    if (hit) return "R7";
    if (!en) return "R3";
    if (we == '0) return "R10";
    if (&we) return "R4";
    return "R5";
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic ae, input logic [NB-1:0] awe, input logic [AW-1:0] aa,
                      input logic [DW-1:0] ad, input logic be, input logic [NB-1:0] bwe,
                      input logic [AW-1:0] ba, input logic [DW-1:0] bd, input string ctag);
    logic awr, bwr, ww, ahit, bhit, eav, ebv;
    string ta, tb;
    a_en = ae; a_we = awe; a_addr = aa; a_din = ad;
    b_en = be; b_we = bwe; b_addr = ba; b_din = bd;
    awr = ae && (awe != '0);
    bwr = be && (bwe != '0);
    ww = awr && bwr && aa == ba;
    ahit = ae && bwr && aa == ba;
    bhit = be && awr && aa == ba;
    eav = ae && !ahit && !(awr && !(&awe));
    ebv = be && !bhit && !(bwr && !(&bwe));
    if (ae) begin
      ea_dout = ww ? POISON : apply(rm[aa], ad, awr ? awe : '0);
      ea_bad = ww ? 1'b1 : ((awr && (&awe)) ? 1'b0 : rb[aa]);
    end
    if (be) begin
      eb_dout = ww ? POISON : apply(rm[ba], bd, bwr ? bwe : '0);
      eb_bad = ww ? 1'b1 : ((bwr && (&bwe)) ? 1'b0 : rb[ba]);
    end
    if (ww) begin
      rm[aa] = POISON; rb[aa] = 1'b1;
    end else begin
      if (awr) begin rm[aa] = apply(rm[aa], ad, awe); if (&awe) rb[aa] = 1'b0; end
      if (bwr) begin rm[ba] = apply(rm[ba], bd, bwe); if (&bwe) rb[ba] = 1'b0; end
    end
    ta = (ctag != "") ? ctag : tag_of(ae, awe, ahit, ww);
    tb = (ctag != "") ? ctag : tag_of(be, bwe, bhit, ww);
    @(negedge clk);
    chk(a_dout == ea_dout, ta, "a_dout R2", 32'(a_dout), 32'(ea_dout));
    chk(a_vld == eav, ta, "a_vld", 32'(a_vld), 32'(eav));
    chk(a_coll == ahit, ta, "a_coll", 32'(a_coll), 32'(ahit));
    chk(a_bad == ea_bad, ta, "a_bad R8", 32'(a_bad), 32'(ea_bad));
    chk(b_dout == eb_dout, tb, "b_dout R2", 32'(b_dout), 32'(eb_dout));
    chk(b_vld == ebv, tb, "b_vld", 32'(b_vld), 32'(ebv));
    chk(b_coll == bhit, tb, "b_coll", 32'(b_coll), 32'(bhit));
    chk(b_bad == eb_bad, tb, "b_bad R8", 32'(b_bad), 32'(eb_bad));
  endtask

  task automatic rd_a(input logic [AW-1:0] ad, input string t);
    step(1, '0, ad, '0, 0, '0, '0, '0, t);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < (1 << AW); i++) begin rm[i] = '0; rb[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_vld && !a_coll && !b_vld && !b_coll, "R1", "flags after reset",
        {a_vld, a_coll, b_vld, b_coll}, 0);
    for (int i = 0; i < 4; i++) step(1, '0, AW'(i), '0, 1, '0, AW'(i + 200), '0, "R1");

    step(1, 3'b011, 0, 24'h1A2B3C, 0, '0, 0, '0, "");
    step(1, 3'b010, 0, 24'h4D5E6F, 0, '0, 0, '0, "");
    step(1, 3'b101, 0, 24'h778899, 0, '0, 0, '0, "");
    step(1, 3'b000, 0, 24'hAABBCC, 0, '0, 0, '0, "");
    step(1, 3'b110, 0, 24'hDDEEF0, 0, '0, 0, '0, "");
    step(1, 3'b010, 0, 24'h123456, 0, '0, 0, '0, "");
    rd_a(0, "R2");

    step(0, 3'b111, 0, 24'hFFFFFF, 0, 3'b111, 0, 24'hFFFFFF, "R3");
    rd_a(0, "R3");

    step(1, 3'b111, 10, 24'h0A0A0A, 1, 3'b111, 11, 24'h0B0B0B, "R9");
    step(1, '0, 11, '0, 1, '0, 10, '0, "R9");

    step(1, 3'b111, 20, 24'h111111, 1, '0, 20, '0, "R7");
    step(1, '0, 20, '0, 1, 3'b001, 20, 24'h2222EE, "R7");
    rd_a(20, "R7");

    step(1, 3'b111, 5, 24'h010203, 1, 3'b100, 5, 24'h040506, "R6");
    rd_a(5, "R8");
    step(1, 3'b011, 5, 24'h0000CD, 0, '0, 0, '0, "R8");
    rd_a(5, "R8");
    step(0, '0, 0, '0, 1, 3'b111, 5, 24'hC0FFEE, "R8");
    rd_a(5, "R8");

    for (int n = 0; n < 400; n++)
      step(($urandom % 4) != 0, NB'($urandom), AW'($urandom % 4), DW'($urandom),
           ($urandom % 4) != 0, NB'($urandom), AW'($urandom % 4), DW'($urandom), "");

    for (int i = 0; i < 4; i++) rd_a(AW'(i), "R2");
    a_en = 0; b_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule